// File: doc/BRIEF.md
# Instruction Prefetch Buffer with Flush

This block sits between an instruction sequencer and a bus master. The sequencer asks for one 32-bit instruction word at a time by byte address. While prefetching is on, the block keeps an aligned window of eight words. It fills that window from main memory in one or two burst reads and serves later fetches that fall inside the window straight from its own storage. While prefetching is off, every fetch becomes a single-word read on the bus.

The prefetch burst length follows a configured maximum burst code. When the configuration allows bursts shorter than four words, the block turns itself off and passes fetches through. With cache-aware reads enabled, the fill uses a line-read command when one burst covers the whole window, and a multiple-line read when two are needed.

The decoder of a memory-move instruction drives a flush strobe. This strobe empties the buffer, so the sequencer re-reads code that the move may have modified. A no-flush qualifier on the same strobe cancels the flush.

Top module: `ifetch_prefetch`

## Requirements
- R1: After reset `rd_req` and `fetch_ack` are low and the buffer holds no valid word, so the first fetch misses.
- R2: With `pf_enable` low, each fetch issues exactly one read with `rd_len` = 1, `rd_cmd` = 0 (plain) and `rd_addr` equal to `fetch_addr`. The returned beat is delivered with `fetch_ack`, and repeated fetches of one address each go to the bus.
- R3: `burst_code` c selects a maximum of 2^(c+1) beats for c = 0..6 and 128 beats for c = 7. Code 0 (two beats, below the minimum of four) makes the block behave exactly as in R2.
- R4: The prefetch burst is min(8, configured beats). A fill covers the 8-word window aligned to 32 bytes, starting at its first word. It uses one burst of 8, or two bursts of 4 with the second at window base + 16.
- R5: `rd_cmd` for a fill is 0 (plain) when `cache_rd_en` is low, 1 (read line) for a single-burst fill, and 2 (read multiple) for a two-burst fill.
- R6: A fetch whose window is buffered and whose word has arrived gets `fetch_ack` with that word one cycle after it is sampled, and issues no bus read.
- R7: A fetch outside the buffered window invalidates the buffer and starts a fill of the requested address's window. The fetch is acknowledged with the correct word once that word arrives.
- R8: `flush_strobe` high with `flush_keep` low empties the buffer, so the next fetch of a previously buffered word reads memory again and returns its current contents.
- R9: `flush_strobe` high with `flush_keep` high has no effect: the next fetch of a buffered word hits with the buffered data and no bus read.
- R10: A flush during a fill discards the rest of that burst's beats without marking them valid, and the second burst of the fill is not issued.
- R11: `rd_req` stays high with `rd_addr`, `rd_len` and `rd_cmd` stable until `rd_gnt`, and a new request is raised only after the last beat of the previous burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pf_enable | input | 1 | Prefetch on |
| cache_rd_en | input | 1 | Use cache-aware read commands for fills |
| burst_code | input | 3 | Configured maximum burst length code |
| fetch_req | input | 1 | Fetch request, held until acknowledged |
| fetch_addr | input | 32 | Byte address of the wanted word |
| fetch_ack | output | 1 | One-cycle pulse, fetch_data valid |
| fetch_data | output | 32 | Instruction word returned |
| flush_strobe | input | 1 | Memory-move instruction decoded |
| flush_keep | input | 1 | No-flush qualifier of that instruction |
| rd_req | output | 1 | Burst read request to the bus master |
| rd_addr | output | 32 | Burst start byte address |
| rd_len | output | 8 | Burst length in words |
| rd_cmd | output | 2 | 0 plain, 1 read line, 2 read multiple |
| rd_gnt | input | 1 | Request accepted |
| rd_beat_vld | input | 1 | Returned data beat valid |
| rd_beat_data | input | 32 | Returned data beat |

## Verification
A hit is due exactly one cycle after the clock edge that samples the request. The bench drives the request at a falling edge and counts falling edges until `fetch_ack` is seen, so a hit must read a latency of one. A miss or pass-through fetch depends on the memory model's response time, so it is checked for data and for the request log rather than for a cycle count. The bus request rises one edge after the deciding fetch or last beat, and the memory model records each request at the falling edge that grants it. Counts of recorded requests are taken only after a settling gap of thirty cycles, when a fill's second burst must already have appeared.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
    typedef enum logic [1:0] {
        CMD_PLAIN = 2'd0,
        CMD_LINE  = 2'd1,
        CMD_MULTI = 2'd2
    } rdcmd_e;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_REQ  = 2'd1,
        F_DATA = 2'd2
    } fsm_e;
endpackage

// File: rtl/ipf_burst_plan.sv
module ipf_burst_plan
    import ipf_pkg::*;
#(
    parameter int LINE_WORDS = 8,
    parameter int MIN_BURST  = 4,
    parameter int LEN_W      = 8
) (
    input  logic             enable,
    input  logic             cache_en,
    input  logic [2:0]       code,
    output logic             pf_on,
    output logic [LEN_W-1:0] burst,
    output rdcmd_e           cmd
);
    localparam logic [LEN_W-1:0] LINE_L = LEN_W'(LINE_WORDS);
    localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_BURST);

    logic [3:0]       shift_amt;
    logic [LEN_W-1:0] cfg_beats;

    always_comb begin
        shift_amt = (code == 3'd7) ? 4'd7 : ({1'b0, code} + 4'd1);
        cfg_beats = LEN_W'(1) << shift_amt;
        pf_on     = enable && (cfg_beats >= MIN_L);
        burst     = (cfg_beats < LINE_L) ? cfg_beats : LINE_L;
        if (!cache_en)          cmd = CMD_PLAIN;
        else if (burst < LINE_L) cmd = CMD_MULTI;
        else                    cmd = CMD_LINE;
    end

    // R3
    always_comb begin
        min_burst_chk: assert (!pf_on || burst >= MIN_L || $isunknown(code));
    end
endmodule

// File: rtl/ipf_line_store.sv
module ipf_line_store #(
    parameter int WORDS = 8,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata,
    output logic [WORDS-1:0] vld
);
    logic [DW-1:0]    word_q [WORDS];
    logic [WORDS-1:0] vld_q;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [DW-1:0] word_d;
        logic          vld_d;
        always_comb begin
            word_d = word_q[i];
            vld_d  = vld_q[i];
            if (clr) begin
                vld_d = 1'b0;
            end else if (we && widx == IW'(i)) begin
                word_d = wdata;
                vld_d  = 1'b1;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[i] <= '0;
                vld_q[i]  <= 1'b0;
            end else begin
                word_q[i] <= word_d;
                vld_q[i]  <= vld_d;
            end
        end
    end

    assign rdata = word_q[ridx];
    assign vld   = vld_q;

    // R8
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld_q == '0));
endmodule

// File: rtl/ifetch_prefetch.sv
module ifetch_prefetch
    import ipf_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LEN_W      = 8,
    parameter int LINE_WORDS = 8,
    parameter int MIN_BURST  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pf_enable,
    input  logic             cache_rd_en,
    input  logic [2:0]       burst_code,
    input  logic             fetch_req,
    input  logic [AW-1:0]    fetch_addr,
    output logic             fetch_ack,
    output logic [DW-1:0]    fetch_data,
    input  logic             flush_strobe,
    input  logic             flush_keep,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    output logic [LEN_W-1:0] rd_len,
    output logic [1:0]       rd_cmd,
    input  logic             rd_gnt,
    input  logic             rd_beat_vld,
    input  logic [DW-1:0]    rd_beat_data
);
    localparam int OFF_W   = $clog2(LINE_WORDS);
    localparam int WIN_LSB = OFF_W + 2;
    localparam int BASE_W  = AW - WIN_LSB;
    localparam logic [OFF_W:0] LINE_F = (OFF_W + 1)'(LINE_WORDS);

    typedef struct packed {
        fsm_e             st;
        logic             ack;
        logic [DW-1:0]    rdata;
        logic             req;
        logic [AW-1:0]    addr;
        logic [LEN_W-1:0] len;
        rdcmd_e           cmd;
        logic [BASE_W-1:0] base;
        logic             win;
        logic [LEN_W-1:0] left;
        logic [OFF_W:0]   fill;
        logic [OFF_W:0]   wpos;
        logic             drop;
        logic             pt;
    } ctl_t;

    ctl_t q, d;

    logic             pf_on;
    logic [LEN_W-1:0] burst;
    rdcmd_e           fill_cmd;

    ipf_burst_plan #(
        .LINE_WORDS(LINE_WORDS), .MIN_BURST(MIN_BURST), .LEN_W(LEN_W)
    ) u_plan (
        .enable(pf_enable), .cache_en(cache_rd_en), .code(burst_code),
        .pf_on(pf_on), .burst(burst), .cmd(fill_cmd)
    );

    logic                  st_clr, st_we;
    logic [OFF_W-1:0]      st_widx;
    logic [DW-1:0]         st_rdata;
    logic [LINE_WORDS-1:0] st_vld;
    logic [OFF_W-1:0]      rd_idx;

    assign rd_idx = fetch_addr[WIN_LSB-1:2];

    ipf_line_store #(.WORDS(LINE_WORDS), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(st_clr), .we(st_we),
        .widx(st_widx), .wdata(rd_beat_data), .ridx(rd_idx),
        .rdata(st_rdata), .vld(st_vld)
    );

    logic flush_eff, kill, busy_pt, busy_fill, in_win, take, hit;

    always_comb begin
        d       = q;
        d.ack   = 1'b0;
        st_clr  = 1'b0;
        st_we   = 1'b0;
        st_widx = q.wpos[OFF_W-1:0];

        flush_eff = flush_strobe && !flush_keep;
        kill      = flush_eff || !pf_on;
        busy_pt   = (q.st != F_IDLE) && q.pt;
        busy_fill = (q.st != F_IDLE) && !q.pt;
        in_win    = q.win && (fetch_addr[AW-1:WIN_LSB] == q.base);
        take      = fetch_req && !q.ack && !busy_pt;
        hit       = take && pf_on && !flush_eff && in_win && st_vld[rd_idx];

        if (kill) begin
            d.win  = 1'b0;
            st_clr = 1'b1;
            if (busy_fill) d.drop = 1'b1;
        end

        if (take && pf_on && !flush_eff && !in_win && busy_fill) begin
            d.win  = 1'b0;
            d.drop = 1'b1;
            st_clr = 1'b1;
        end

        if (hit) begin
            d.ack   = 1'b1;
            d.rdata = st_rdata;
        end

        unique case (q.st)
            F_IDLE: begin
                if (take && !hit && !flush_eff) begin
                    d.st  = F_REQ;
                    d.req = 1'b1;
                    if (!pf_on) begin
                        d.addr = fetch_addr;
                        d.len  = LEN_W'(1);
                        d.cmd  = CMD_PLAIN;
                        d.left = LEN_W'(1);
                        d.pt   = 1'b1;
                    end else begin
                        st_clr = 1'b1;
                        d.win  = 1'b1;
                        d.base = fetch_addr[AW-1:WIN_LSB];
                        d.addr = {fetch_addr[AW-1:WIN_LSB], {WIN_LSB{1'b0}}};
                        d.len  = burst;
                        d.cmd  = fill_cmd;
                        d.left = burst;
                        d.fill = burst[OFF_W:0];
                        d.wpos = '0;
                        d.pt   = 1'b0;
                        d.drop = 1'b0;
                    end
                end
            end
            F_REQ: begin
                if (rd_gnt) begin
                    d.req = 1'b0;
                    d.st  = F_DATA;
                end
            end
            F_DATA: begin
                if (rd_beat_vld) begin
                    d.left = q.left - LEN_W'(1);
                    if (q.pt) begin
                        d.ack   = 1'b1;
                        d.rdata = rd_beat_data;
                    end else if (!d.drop) begin
                        st_we  = 1'b1;
                        d.wpos = q.wpos + 1'b1;
                    end
                    if (q.left == LEN_W'(1)) begin
                        if (q.pt || d.drop || q.fill >= LINE_F) begin
                            d.st   = F_IDLE;
                            d.pt   = 1'b0;
                            d.drop = 1'b0;
                        end else begin
                            d.st   = F_REQ;
                            d.req  = 1'b1;
                            d.addr = q.addr + (AW'(q.len) << 2);
                            d.left = q.len;
                            d.fill = q.fill + q.len[OFF_W:0];
                        end
                    end
                end
            end
            default: d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= F_IDLE;
        end else begin
            q <= d;
        end
    end

    assign fetch_ack  = q.ack;
    assign fetch_data = q.rdata;
    assign rd_req     = q.req;
    assign rd_addr    = q.addr;
    assign rd_len     = q.len;
    assign rd_cmd     = q.cmd;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr) && $stable(rd_len) && $stable(rd_cmd)));

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ack |=> !fetch_ack);

    // R2
    pt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_req) && $past(!pf_enable)) |-> (rd_len == LEN_W'(1) && rd_cmd == CMD_PLAIN));

    // R4
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_len <= LEN_W'(LINE_WORDS)));

    // R10
    drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.drop && rd_beat_vld) |=> ($countones(st_vld) <= $past($countones(st_vld))));

    // R1
    no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == F_IDLE) |-> !rd_req);
endmodule

// File: tb/ifetch_prefetch_tb.sv
module ifetch_prefetch_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pf_enable, cache_rd_en;
    logic [2:0]  burst_code;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ack;
    logic [31:0] fetch_data;
    logic        flush_strobe, flush_keep;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic [7:0]  rd_len;
    logic [1:0]  rd_cmd;
    logic        rd_gnt, rd_beat_vld;
    logic [31:0] rd_beat_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifetch_prefetch u_dut (
        .clk(clk), .rst_n(rst_n), .pf_enable(pf_enable), .cache_rd_en(cache_rd_en),
        .burst_code(burst_code), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data), .flush_strobe(flush_strobe),
        .flush_keep(flush_keep), .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
        .rd_cmd(rd_cmd), .rd_gnt(rd_gnt), .rd_beat_vld(rd_beat_vld),
        .rd_beat_data(rd_beat_data)
    );

    int          n_vec = 0;
    int          n_bad = 0;
    logic [7:0]  gen = 8'h11;
    int          req_cnt = 0;
    logic [31:0] log_addr [8];
    logic [7:0]  log_len  [8];
    logic [1:0]  log_cmd  [8];

    function automatic logic [31:0] memword(input logic [31:0] a);
        return {gen, a[23:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model, all activity at the falling edge
    initial begin
        logic        busy;
        logic [31:0] cur;
        int          left;
        busy = 1'b0; cur = '0; left = 0;
        rd_gnt = 1'b0; rd_beat_vld = 1'b0; rd_beat_data = '0;
        forever begin
            @(negedge clk);
            rd_beat_vld = 1'b0;
            if (rd_gnt) begin
                rd_gnt = 1'b0;
                busy   = 1'b1;
            end
            if (busy) begin
                rd_beat_vld  = 1'b1;
                rd_beat_data = memword(cur);
                cur  = cur + 32'd4;
                left = left - 1;
                if (left == 0) busy = 1'b0;
            end else if (rd_req && rst_n) begin
                rd_gnt = 1'b1;
                cur    = rd_addr;
                left   = int'(rd_len);
                log_addr[req_cnt % 8] = rd_addr;
                log_len[req_cnt % 8]  = rd_len;
                log_cmd[req_cnt % 8]  = rd_cmd;
                req_cnt++;
            end
        end
    end

    task automatic fetch(input logic [31:0] a, output logic [31:0] dat, output int lat);
        @(negedge clk);
        fetch_addr = a;
        fetch_req  = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!fetch_ack && lat < 300);
        dat = fetch_data;
        fetch_req = 1'b0;
        if (lat >= 300) chk(1'b0, "fetch timeout", a, 32'h0);
    endtask

    task automatic pulse_flush(input logic keep);
        flush_strobe = 1'b1;
        flush_keep   = keep;
        @(negedge clk);
        flush_strobe = 1'b0;
        flush_keep   = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        logic [31:0] dat;
        int lat, c0, c1;
        rst_n = 1'b0; pf_enable = 1'b0; cache_rd_en = 1'b0; burst_code = 3'd2;
        fetch_req = 1'b0; fetch_addr = '0; flush_strobe = 1'b0; flush_keep = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(rd_req == 1'b0, "R1 rd_req", 32'(rd_req), 32'h0);
        chk(fetch_ack == 1'b0, "R1 fetch_ack", 32'(fetch_ack), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 pass-through with prefetch off
        for (int k = 0; k < 3; k++) begin
            logic [31:0] a;
            a  = 32'h0000_4000 + 32'(k) * 32'h24;
            c0 = req_cnt;
            fetch(a, dat, lat);
            chk(dat == memword(a), "R2 data", dat, memword(a));
            chk(req_cnt - c0 == 1, "R2 one read", 32'(req_cnt - c0), 32'h1);
            chk(log_len[c0 % 8] == 8'd1, "R2 len", 32'(log_len[c0 % 8]), 32'h1);
            chk(log_cmd[c0 % 8] == 2'd0, "R2 cmd", 32'(log_cmd[c0 % 8]), 32'h0);
            chk(log_addr[c0 % 8] == a, "R2 addr", log_addr[c0 % 8], a);
        end

        // R1 buffer empty: first prefetch fetch must reach the bus
        pf_enable = 1'b1; burst_code = 3'd2; cache_rd_en = 1'b1;
        c0 = req_cnt;
        fetch(32'h0000_8000, dat, lat);
        chk(req_cnt - c0 >= 1, "R1 empty after reset", 32'(req_cnt - c0), 32'h1);
        repeat (30) @(negedge clk);

        // sweep over burst codes and cache setting: R3 R4 R5 R6 R7
        for (int code = 0; code < 8; code++) begin
            for (int ch = 0; ch < 2; ch++) begin
                logic [31:0] base;
                int exp_len, exp_nreq, exp_cmd;
                base = 32'h0001_0000 + 32'(code * 2 + ch) * 32'h100;
                @(negedge clk);
                burst_code  = 3'(code);
                cache_rd_en = ch[0];
                c0 = req_cnt;
                fetch(base + 32'd12, dat, lat);
                chk(dat == memword(base + 32'd12), "R7 miss data", dat, memword(base + 32'd12));
                repeat (30) @(negedge clk);
                if (code == 0) begin
                    chk(req_cnt - c0 == 1, "R3 disabled one read", 32'(req_cnt - c0), 32'h1);
                    chk(log_len[c0 % 8] == 8'd1, "R3 disabled len", 32'(log_len[c0 % 8]), 32'h1);
                    chk(log_cmd[c0 % 8] == 2'd0, "R3 disabled cmd", 32'(log_cmd[c0 % 8]), 32'h0);
                    chk(log_addr[c0 % 8] == base + 32'd12, "R3 disabled addr", log_addr[c0 % 8], base + 32'd12);
                    c1 = req_cnt;
                    fetch(base + 32'd12, dat, lat);
                    chk(req_cnt - c1 == 1, "R3 disabled refetch reads", 32'(req_cnt - c1), 32'h1);
                    chk(dat == memword(base + 32'd12), "R3 disabled data", dat, memword(base + 32'd12));
                end else begin
                    exp_len  = (code == 1) ? 4 : 8;
                    exp_nreq = (code == 1) ? 2 : 1;
                    exp_cmd  = (ch == 0) ? 0 : ((code == 1) ? 2 : 1);
                    chk(req_cnt - c0 == exp_nreq, "R4 burst count", 32'(req_cnt - c0), 32'(exp_nreq));
                    chk(log_addr[c0 % 8] == base, "R4 fill base", log_addr[c0 % 8], base);
                    chk(int'(log_len[c0 % 8]) == exp_len, "R3 burst len", 32'(log_len[c0 % 8]), 32'(exp_len));
                    chk(int'(log_cmd[c0 % 8]) == exp_cmd, "R5 fill cmd", 32'(log_cmd[c0 % 8]), 32'(exp_cmd));
                    if (exp_nreq == 2) begin
                        chk(log_addr[(c0 + 1) % 8] == base + 32'd16, "R4 second addr",
                            log_addr[(c0 + 1) % 8], base + 32'd16);
                        chk(int'(log_cmd[(c0 + 1) % 8]) == exp_cmd, "R5 second cmd",
                            32'(log_cmd[(c0 + 1) % 8]), 32'(exp_cmd));
                    end
                    c1 = req_cnt;
                    for (int w = 0; w < 8; w++) begin
                        fetch(base + 32'(w * 4), dat, lat);
                        chk(dat == memword(base + 32'(w * 4)), "R6 hit data", dat, memword(base + 32'(w * 4)));
                        chk(lat == 1, "R6 hit latency", 32'(lat), 32'h1);
                    end
                    chk(req_cnt == c1, "R6 no bus on hits", 32'(req_cnt), 32'(c1));
                end
            end
        end

        // R7 window replacement
        burst_code = 3'd3; cache_rd_en = 1'b1;
        fetch(32'h0002_0004, dat, lat);
        repeat (30) @(negedge clk);
        c0 = req_cnt;
        fetch(32'h0002_0444, dat, lat);
        chk(dat == memword(32'h0002_0444), "R7 new window data", dat, memword(32'h0002_0444));
        chk(log_addr[c0 % 8] == 32'h0002_0440, "R7 new window base", log_addr[c0 % 8], 32'h0002_0440);
        repeat (30) @(negedge clk);
        c0 = req_cnt;
        fetch(32'h0002_0004, dat, lat);
        chk(req_cnt - c0 == 1, "R7 old window refetched", 32'(req_cnt - c0), 32'h1);
        repeat (30) @(negedge clk);

        // R9 no-flush qualifier has no effect
        @(negedge clk);
        pulse_flush(1'b1);
        gen = 8'h22;
        c0 = req_cnt;
        fetch(32'h0002_000C, dat, lat);
        chk(dat == {8'h11, 24'h02_000C}, "R9 kept data", dat, {8'h11, 24'h02_000C});
        chk(req_cnt == c0, "R9 no reload", 32'(req_cnt), 32'(c0));

        // R8 flush empties buffer
        @(negedge clk);
        pulse_flush(1'b0);
        c0 = req_cnt;
        fetch(32'h0002_000C, dat, lat);
        chk(dat == memword(32'h0002_000C), "R8 reloaded data", dat, memword(32'h0002_000C));
        chk(req_cnt - c0 >= 1, "R8 reload read", 32'(req_cnt - c0), 32'h1);
        repeat (30) @(negedge clk);

        // R10 flush during an in-flight burst (two bursts of four)
        burst_code = 3'd1;
        c0 = req_cnt;
        fetch(32'h0003_0000, dat, lat);
        pulse_flush(1'b0);
        gen = 8'h33;
        repeat (30) @(negedge clk);
        chk(req_cnt - c0 == 1, "R10 second burst dropped", 32'(req_cnt - c0), 32'h1);
        c1 = req_cnt;
        fetch(32'h0003_0008, dat, lat);
        chk(dat == memword(32'h0003_0008), "R10 discarded beat", dat, memword(32'h0003_0008));
        chk(req_cnt - c1 >= 1, "R10 refill issued", 32'(req_cnt - c1), 32'h1);
        repeat (30) @(negedge clk);

        finish_run();
    end
endmodule